// File: doc/BRIEF.md
# Flash Protected-Range Checker

This block sits in front of a flash controller and decides, before any flash cycle starts, whether an access may go ahead. It holds five range registers. Each register names a window of the flash address space in 4 KiB granules, with one enable that blocks reads and another that blocks writes and erases inside that window. An access is presented as an address, a kind and a one-cycle strobe. One clock later the block answers with a response pulse, a deny flag and the index of the lowest-numbered range that caused the denial.

Configuration software programs the range registers through a small write and read port. A lock request seals the registers. After that, writes are dropped, reads still return the stored words, and only a reset opens the registers again. All five windows are compared in parallel, and a fixed priority picks the lowest matching index.

There are two small state machines. The response machine has two states. RSP_IDLE moves to RSP_REPLY when a strobe arrives. RSP_REPLY stays in RSP_REPLY while strobes keep coming and returns to RSP_IDLE when they stop. The lock machine also has two states. LK_OPEN moves to LK_SEALED on a lock request. LK_SEALED has no exit except reset.

Top module: `flash_range_guard`

## Requirements
- R1: After reset every range register reads zero, the registers are unlocked, and rsp_valid, rsp_deny and rsp_idx are all zero.
- R2: rsp_valid is high in exactly the cycle after each cycle in which req_valid is high. Back-to-back strobes produce back-to-back responses.
- R3: A modifying access (req_kind 01 write, 10 erase) is denied when its address lies inside a range whose write enable (bit 31) is set.
- R4: A read (req_kind 00) is denied when its address lies inside a range whose read enable (bit 15) is set. A read is not blocked by the write enable alone, and a write is not blocked by the read enable alone.
- R5: A range covers byte addresses from base*4096 through limit*4096+4095, both ends included. Base is bits 12:0 of the register and limit is bits 28:16. The address one byte outside either end is not covered.
- R6: A register that is all zeros is unused. A range whose base is greater than its limit covers no address.
- R7: When several enabled ranges match, rsp_idx reports the lowest index. When the access is allowed, or when rsp_valid is low, rsp_deny is 0 and rsp_idx is 0.
- R8: cfg_rdata shows, without any clock delay, the register selected by cfg_idx. Only bits 31, 28:16, 15 and 12:0 are stored, and every other bit reads 0.
- R9: After a cycle with lock_req high, all later register writes are ignored, readback still works, and the lock stays in force until reset.
- R10: A write to an index of 5 or above changes nothing, and a read from such an index returns 0.
- R11: req_kind 11 is handled like a write for the protection check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index for write and readback |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| lock_req | input | 1 | Seals the registers until reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 25 | Flash byte address of the access |
| req_kind | input | 2 | 00 read, 01 write, 10 erase, 11 treated as write |
| rsp_valid | output | 1 | Result strobe, one cycle after req_valid |
| rsp_deny | output | 1 | Access blocked |
| rsp_idx | output | 3 | Lowest matching range index when denied |

## Verification
The bench probes the bytes at both ends of a window, and the bytes just outside it. A design that compares the limit against the granule start, or that uses an exclusive bound, would allow the final 4 KiB of a window or deny the first byte after it. Overlapping windows, one with the read enable and one with the write enable, show whether each access kind is tested against the correct enable and whether the lowest index wins. The bench also programs an inverted window, writes to an index beyond the last register, writes reserved bits, and writes after the lock. Each of these catches a design that stores garbage, lets writes leak through the lock, or matches on an empty window.

// File: rtl/frg_pkg.sv
package frg_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_ERASE = 2'b10,
        ACC_SPARE = 2'b11
    } acc_kind_e;

    typedef enum logic {RSP_IDLE, RSP_REPLY} rsp_state_e;
    typedef enum logic {LK_OPEN, LK_SEALED} lock_state_e;

    localparam int RPE_BIT   = 15;
    localparam int WPE_BIT   = 31;
    localparam int LIMIT_LSB = 16;
endpackage

// File: rtl/frg_regfile.sv
module frg_regfile
    import frg_pkg::*;
#(
    parameter int NUM     = 5,
    parameter int FIELD_W = 13,
    parameter int IDX_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [31:0]          cfg_wdata,
    input  logic                 lock_req,
    output logic [31:0]          cfg_rdata,
    output logic [NUM-1:0][31:0] range_regs,
    output logic                 sealed
);
    localparam logic [31:0] FIELD_ONES = (32'd1 << FIELD_W) - 32'd1;
    localparam logic [31:0] KEEP_MASK  = (32'd1 << WPE_BIT) | (32'd1 << RPE_BIT)
                                       | (FIELD_ONES << LIMIT_LSB) | FIELD_ONES;

    lock_state_e lk_q, lk_d;
    logic [NUM-1:0][31:0] regs_q;

    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_OPEN:   if (lock_req) lk_d = LK_SEALED;
            LK_SEALED: lk_d = LK_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_OPEN;
        else        lk_q <= lk_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (cfg_we && lk_q == LK_OPEN) begin
            for (int i = 0; i < NUM; i++) begin
                if (cfg_idx == IDX_W'(i)) regs_q[i] <= cfg_wdata & KEEP_MASK;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM; i++) begin
            if (cfg_idx == IDX_W'(i)) cfg_rdata = regs_q[i];
        end
    end

    assign range_regs = regs_q;
    assign sealed     = (lk_q == LK_SEALED);
endmodule

// File: rtl/frg_window.sv
module frg_window
    import frg_pkg::*;
#(
    parameter int FIELD_W = 13
) (
    input  logic [31:0]        entry,
    input  logic [FIELD_W-1:0] granule,
    input  logic               is_read,
    output logic               hit
);
    logic [FIELD_W-1:0] lo_g, hi_g;
    logic               in_span, armed, used;

    assign lo_g    = entry[FIELD_W-1:0];
    assign hi_g    = entry[LIMIT_LSB +: FIELD_W];
    assign used    = |entry;
    assign armed   = is_read ? entry[RPE_BIT] : entry[WPE_BIT];
    assign in_span = (granule >= lo_g) && (granule <= hi_g);
    assign hit     = used && armed && in_span;
endmodule

// File: rtl/frg_pick.sv
module frg_pick #(
    parameter int NUM   = 5,
    parameter int IDX_W = 3
) (
    input  logic [NUM-1:0]   hits,
    output logic             any_hit,
    output logic [IDX_W-1:0] first_idx
);
    always_comb begin
        first_idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hits[i]) first_idx = IDX_W'(i);
        end
    end
    assign any_hit = |hits;
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
    import frg_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int ADDR_W     = 25,
    parameter int GRAN_SHIFT = 12,
    localparam int FIELD_W   = ADDR_W - GRAN_SHIFT,
    localparam int IDX_W     = $clog2(NUM_RANGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              lock_req,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic              rsp_deny,
    output logic [IDX_W-1:0]  rsp_idx
);
    logic [NUM_RANGES-1:0][31:0] range_regs;
    logic [NUM_RANGES-1:0]       hits;
    logic                        lock_sealed, any_hit, is_read;
    logic [IDX_W-1:0]            first_idx;
    logic [FIELD_W-1:0]          granule;
    logic                        unused_low;
    rsp_state_e                  st_q, st_d;

    assign granule    = req_addr[ADDR_W-1:GRAN_SHIFT];
    assign unused_low = ^req_addr[GRAN_SHIFT-1:0];
    assign is_read    = (acc_kind_e'(req_kind) == ACC_READ);

    frg_regfile #(.NUM(NUM_RANGES), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .lock_req(lock_req), .cfg_rdata(cfg_rdata),
        .range_regs(range_regs), .sealed(lock_sealed)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        frg_window #(.FIELD_W(FIELD_W)) u_win (
            .entry(range_regs[g]), .granule(granule),
            .is_read(is_read), .hit(hits[g])
        );
    end

    frg_pick #(.NUM(NUM_RANGES), .IDX_W(IDX_W)) u_pick (
        .hits(hits), .any_hit(any_hit), .first_idx(first_idx)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RSP_IDLE:  if (req_valid) st_d = RSP_REPLY;
            RSP_REPLY: if (!req_valid) st_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RSP_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_deny <= 1'b0;
            rsp_idx  <= '0;
        end else if (req_valid && any_hit) begin
            rsp_deny <= 1'b1;
            rsp_idx  <= first_idx;
        end else begin
            rsp_deny <= 1'b0;
            rsp_idx  <= '0;
        end
    end

    assign rsp_valid = (st_q == RSP_REPLY);
endmodule

// File: rtl/frg_chk.sv
module frg_chk #(
    parameter int NUM   = 5,
    parameter int IDX_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 rsp_valid,
    input logic                 rsp_deny,
    input logic [IDX_W-1:0]     rsp_idx,
    input logic                 sealed,
    input logic [NUM-1:0][31:0] range_regs
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R7
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_deny && rsp_idx == '0));
    // R7
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_deny |-> (int'(rsp_idx) < NUM));
    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> sealed);
    // R9
    lock_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> $stable(range_regs));
endmodule

bind flash_range_guard frg_chk #(.NUM(NUM_RANGES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .rsp_deny(rsp_deny), .rsp_idx(rsp_idx), .sealed(lock_sealed),
    .range_regs(range_regs)
);

// File: tb/flash_range_guard_bench.sv
module flash_range_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, lock_req = 1'b0, req_valid = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [24:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] cfg_rdata;
    logic        rsp_valid, rsp_deny;
    logic [2:0]  rsp_idx;

    always #10 clk = ~clk;

    flash_range_guard u_flash_range_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lock_req(lock_req),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_deny(rsp_deny), .rsp_idx(rsp_idx)
    );

    int    checks = 0, errors = 0;
    string phase = "R1";
    bit    done = 0;

    // Behavioural reference: byte-address windows, queue-free arrays.
    logic [31:0] m_reg [5];
    bit          m_lock, e_valid, e_deny;
    int          e_idx;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) m_reg[i] = 32'h0;
            m_lock = 0; e_valid = 0; e_deny = 0; e_idx = 0;
        end else begin
            e_valid = req_valid; e_deny = 0; e_idx = 0;
            if (req_valid) begin
                for (int i = 4; i >= 0; i--) begin
                    longint lo, hi;
                    bit en;
                    lo = longint'(m_reg[i] & 32'h1FFF) * 4096;
                    hi = longint'((m_reg[i] >> 16) & 32'h1FFF) * 4096 + 4095;
                    en = (req_kind == 2'b00) ? m_reg[i][15] : m_reg[i][31];
                    if (m_reg[i] != 0 && en && longint'(req_addr) >= lo && longint'(req_addr) <= hi) begin
                        e_deny = 1; e_idx = i;
                    end
                end
            end
            if (cfg_we && !m_lock && cfg_idx < 5) m_reg[cfg_idx] = cfg_wdata & 32'h9FFF9FFF;
            if (lock_req) m_lock = 1;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
        end
    endtask

    always begin
        @(posedge clk);
        #5;
        if (!done) begin
            logic [31:0] exp_rd;
            exp_rd = (cfg_idx < 5) ? m_reg[cfg_idx] : 32'h0;
            chk("rsp_valid", 32'(rsp_valid), 32'(e_valid));
            chk("rsp_deny", 32'(rsp_deny), 32'(e_deny));
            chk("rsp_idx", 32'(rsp_idx), 32'(e_idx));
            chk("cfg_rdata", cfg_rdata, exp_rd);
        end
    end

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic acc(input logic [24:0] a, input logic [1:0] k);
        @(negedge clk); req_valid = 1; req_addr = a; req_kind = k;
        @(negedge clk); req_valid = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        phase = "R1";
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) begin @(negedge clk); cfg_idx = 3'(i); end
        rst_n = 1;
        repeat (2) @(negedge clk);
        phase = "R8";
        wr(4, 32'hFFFF_FFFF);
        @(negedge clk);
        wr(4, 32'h0);
        wr(0, 32'h801F_0010);
        wr(1, 32'h0020_8018);
        phase = "R6"; wr(2, 32'h80FF_8100);
        phase = "R3"; wr(3, 32'h8000_0000);
        phase = "R10"; wr(6, 32'hFFFF_FFFF);
        @(negedge clk); cfg_idx = 3'd7;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin @(negedge clk); cfg_idx = 3'(i); end
        phase = "R5"; acc(25'h00FFFF, 2'b01);
        phase = "R3"; acc(25'h010000, 2'b01);
        phase = "R5"; acc(25'h01FFFF, 2'b10);
        phase = "R4"; acc(25'h020000, 2'b01);
        phase = "R4"; acc(25'h010000, 2'b00);
        phase = "R4"; acc(25'h018000, 2'b00);
        phase = "R7"; acc(25'h018000, 2'b01);
        phase = "R5"; acc(25'h020FFF, 2'b00);
        phase = "R5"; acc(25'h021000, 2'b00);
        phase = "R11"; acc(25'h000800, 2'b10);
        phase = "R11"; acc(25'h015000, 2'b11);
        phase = "R6"; acc(25'h100000, 2'b01);
        phase = "R6"; acc(25'h0FF000, 2'b00);
        phase = "R7"; wr(1, 32'h8020_8018);
        acc(25'h01C000, 2'b01);
        acc(25'h020800, 2'b01);
        phase = "R2";
        @(negedge clk); req_valid = 1; req_addr = 25'h010100; req_kind = 2'b01;
        @(negedge clk); req_addr = 25'h030000;
        @(negedge clk); req_addr = 25'h000000; req_kind = 2'b00;
        @(negedge clk); req_valid = 0;
        @(negedge clk);
        phase = "R9";
        @(negedge clk); lock_req = 1;
        @(negedge clk); lock_req = 0;
        wr(0, 32'h0);
        wr(3, 32'h0);
        @(negedge clk); cfg_idx = 3'd0;
        acc(25'h010000, 2'b01);
        acc(25'h000000, 2'b10);
        phase = "R3";
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            req_valid = 1'($urandom % 2);
            req_addr  = 25'($urandom % 32'h32000);
            req_kind  = 2'($urandom % 4);
            cfg_we    = 1'($urandom % 2);
            cfg_idx   = 3'($urandom % 8);
            cfg_wdata = $urandom;
        end
        @(negedge clk); req_valid = 0; cfg_we = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule